// File: doc/BRIEF.md
# Guest-to-Host Address Walker

This block turns a 48-bit guest-physical address into a host-physical address by following a chain of four page tables held in memory. A root pointer register names the page frame of the top table. Each step reads one 64-bit entry: the table base comes from the step before, and a 9-bit slice of the guest address selects the entry. The entry found at the last step supplies the host page frame, and the 12-bit page offset of the guest address is carried through unchanged.

One translation is accepted at a time. The controller steps through the top, second, third and leaf levels and keeps at most one memory read outstanding. It waits for each read's data before it forms the next address, so a walk always costs four dependent reads. If an entry is marked not present, the walk stops at once and reports a fault that names the level. The memory side tolerates any number of stall cycles on the request and any response latency.

Top module: `gpa_walker`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and mem_req_valid_o is 0.
- R2: A walk issues its reads in the order top, second, third, leaf. The top read uses guest bits 47:39 as the index, then bits 38:30, 29:21 and 20:12. The read address is {table frame, index, 3'b000}, so it equals the table base plus index times 8.
- R3: The top table frame is the root pointer value. Each later table frame is bits 47:12 of the entry read at the level above. All other entry bits are ignored for addressing.
- R4: On success, rsp_hpa_o is {leaf entry bits 47:12, guest bits 11:0}, and rsp_fault_o is 0.
- R5: Bit 0 of an entry is its present flag. When that flag is 0, the walk stops and issues no further read. It answers with rsp_fault_o = 1, rsp_hpa_o = 0 and rsp_lvl_o set to 3 for the top level, 2 for the second, 1 for the third and 0 for the leaf.
- R6: At most one read is outstanding. mem_req_valid_o stays low from the accepting handshake until the response. While ready is low, the valid signal and the address stay steady.
- R7: req_ready_o is 1 only while the walker is idle. A request presented during a walk is not taken and does not change the result of the walk.
- R8: Each accepted request yields exactly one response, a single-cycle pulse of rsp_valid_o.
- R9: A root write (root_we_i = 1) loads root_pfn_i at the clock edge. It affects only requests accepted afterwards; a walk in progress keeps the root it started with.
- R10: The result does not depend on request stall cycles or on response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_we_i | input | 1 | Root pointer write strobe |
| root_pfn_i | input | 36 | Frame number of the top-level table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_gpa_i | input | 48 | Guest-physical address to translate |
| rsp_valid_o | output | 1 | One-cycle result pulse |
| rsp_hpa_o | output | 48 | Host-physical address (0 on fault) |
| rsp_fault_o | output | 1 | Entry not present during walk |
| rsp_lvl_o | output | 2 | Level of faulting entry (3 top .. 0 leaf) |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 48 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read from memory |

## Verification
The bench builds each table chain so that every level sits on a different frame. It also fills the unused high and middle entry bits with junk, which shows whether the next base is taken from the right bit field and from the right level. Guest addresses with distinct index slices show whether each level reads the correct slice. An all-ones address and an all-ones offset test the field edges. For each of the four levels a clear present flag is placed in turn, which separates the fault codes and checks that no read follows the fault. Runs with zero latency, long latency and stalled ready show that the walk tracks the handshake and not fixed timing. Requests presented mid-walk and root writes mid-walk separate the work latched at acceptance from later port activity.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int unsigned LEVELS = 4;
  localparam int unsigned LVL_W  = $clog2(LEVELS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L4,
    ST_L3,
    ST_L2,
    ST_L1,
    ST_DONE
  } walk_st_e;

  function automatic logic [LVL_W-1:0] st_level(walk_st_e s);
    case (s)
      ST_L4:   return 2'd3;
      ST_L3:   return 2'd2;
      ST_L2:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic walk_st_e st_next(walk_st_e s);
    case (s)
      ST_L4:   return ST_L3;
      ST_L3:   return ST_L2;
      ST_L2:   return ST_L1;
      default: return ST_DONE;
    endcase
  endfunction
endpackage

// File: rtl/walk_idx_mux.sv
module walk_idx_mux #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned IDX_W  = 9
) (
  input  logic [ADDR_W-1:0]           gpa_i,
  input  logic [walk_pkg::LVL_W-1:0]  lvl_i,
  output logic [IDX_W-1:0]            idx_o
);
  logic [IDX_W-1:0] fld [walk_pkg::LEVELS];

  for (genvar g = 0; g < walk_pkg::LEVELS; g++) begin : g_fld
    assign fld[g] = gpa_i[PAGE_W + g*IDX_W +: IDX_W];
  end

  assign idx_o = fld[lvl_i];

  logic unused_off;
  assign unused_off = ^gpa_i[PAGE_W-1:0];
endmodule

// File: rtl/walk_entry_dec.sv
module walk_entry_dec #(
  parameter int unsigned ENTRY_W = 64,
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned PAGE_W  = 12
) (
  input  logic [ENTRY_W-1:0]       ent_i,
  output logic                     present_o,
  output logic [ADDR_W-PAGE_W-1:0] pfn_o
);
  assign present_o = ent_i[0];
  assign pfn_o     = ent_i[ADDR_W-1:PAGE_W];

  logic unused_bits;
  assign unused_bits = ^{ent_i[ENTRY_W-1:ADDR_W], ent_i[PAGE_W-1:1]};
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned PAGE_W = 12,
  localparam int unsigned PFN_W = ADDR_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_gpa_i,
  input  logic [PFN_W-1:0]  root_pfn_i,
  output logic              req_ready_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic [ADDR_W-1:0] gpa_o,
  output logic [PFN_W-1:0]  base_o,
  output logic              issue_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic              ent_present_i,
  input  logic [PFN_W-1:0]  ent_pfn_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_hpa_o,
  output logic              rsp_fault_o,
  output logic [LVL_W-1:0]  rsp_lvl_o
);
  walk_st_e          st_q;
  logic [ADDR_W-1:0] gpa_q;
  logic [PFN_W-1:0]  base_q;
  logic              issued_q;
  logic [ADDR_W-1:0] hpa_q;
  logic              fault_q;
  logic [LVL_W-1:0]  flvl_q;
  logic              walking;
  logic              got_rsp;

  assign walking = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign got_rsp = walking && issued_q && mem_rsp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      gpa_q    <= '0;
      base_q   <= '0;
      issued_q <= 1'b0;
      hpa_q    <= '0;
      fault_q  <= 1'b0;
      flvl_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          gpa_q    <= req_gpa_i;
          base_q   <= root_pfn_i;
          issued_q <= 1'b0;
          st_q     <= ST_L4;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: begin
          if (!issued_q && mem_req_ready_i) begin
            issued_q <= 1'b1;
          end else if (got_rsp) begin
            if (!ent_present_i) begin
              fault_q <= 1'b1;
              flvl_q  <= st_level(st_q);
              hpa_q   <= '0;
              st_q    <= ST_DONE;
            end else if (st_q == ST_L1) begin
              fault_q <= 1'b0;
              flvl_q  <= '0;
              hpa_q   <= {ent_pfn_i, gpa_q[PAGE_W-1:0]};
              st_q    <= ST_DONE;
            end else begin
              base_q   <= ent_pfn_i;
              issued_q <= 1'b0;
              st_q     <= st_next(st_q);
            end
          end
        end
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign issue_o     = walking && !issued_q;
  assign lvl_o       = st_level(st_q);
  assign gpa_o       = gpa_q;
  assign base_o      = base_q;
  assign rsp_valid_o = (st_q == ST_DONE);
  assign rsp_hpa_o   = hpa_q;
  assign rsp_fault_o = fault_q;
  assign rsp_lvl_o   = flvl_q;

  // R5
  absent_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    got_rsp && !ent_present_i |=> rsp_valid_o && rsp_fault_o && !issue_o);

  // R4
  leaf_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    got_rsp && ent_present_i && st_q == ST_L1 |=>
      rsp_valid_o && !rsp_fault_o &&
      rsp_hpa_o[PAGE_W-1:0] == $past(gpa_q[PAGE_W-1:0]));

  // R6
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o && mem_req_ready_i |=> !issue_o);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
endmodule

// File: rtl/gpa_walker.sv
module gpa_walker #(
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned ENTRY_W = 64,
  localparam int unsigned PFN_W  = ADDR_W - PAGE_W,
  localparam int unsigned ENT_SH = $clog2(ENTRY_W / 8),
  localparam int unsigned LVL_W  = walk_pkg::LVL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               root_we_i,
  input  logic [PFN_W-1:0]   root_pfn_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_gpa_i,
  output logic               rsp_valid_o,
  output logic [ADDR_W-1:0]  rsp_hpa_o,
  output logic               rsp_fault_o,
  output logic [LVL_W-1:0]   rsp_lvl_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [ADDR_W-1:0]  mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [ENTRY_W-1:0] mem_rsp_data_i
);
  logic [PFN_W-1:0]  root_q;
  logic [LVL_W-1:0]  lvl;
  logic [ADDR_W-1:0] gpa_q;
  logic [PFN_W-1:0]  base_q;
  logic [IDX_W-1:0]  idx;
  logic              ent_present;
  logic [PFN_W-1:0]  ent_pfn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        root_q <= '0;
    else if (root_we_i) root_q <= root_pfn_i;
  end

  walk_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_gpa_i,
    .root_pfn_i      (root_q),
    .req_ready_o,
    .lvl_o           (lvl),
    .gpa_o           (gpa_q),
    .base_o          (base_q),
    .issue_o         (mem_req_valid_o),
    .mem_req_ready_i, .mem_rsp_valid_i,
    .ent_present_i   (ent_present),
    .ent_pfn_i       (ent_pfn),
    .rsp_valid_o, .rsp_hpa_o, .rsp_fault_o, .rsp_lvl_o
  );

  walk_idx_mux #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_idx (
    .gpa_i (gpa_q),
    .lvl_i (lvl),
    .idx_o (idx)
  );

  walk_entry_dec #(.ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dec (
    .ent_i     (mem_rsp_data_i),
    .present_o (ent_present),
    .pfn_o     (ent_pfn)
  );

  assign mem_req_addr_o = {base_q, idx, {ENT_SH{1'b0}}};

  // R6
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R2
  aligned_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[ENT_SH-1:0] == '0);

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !rsp_valid_o);
endmodule

// File: tb/sim_gpa_walker.sv
module sim_gpa_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        root_we = 1'b0;
  logic [35:0] root_pfn = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_gpa = '0;
  logic        rsp_valid;
  logic [47:0] rsp_hpa;
  logic        rsp_fault;
  logic [1:0]  rsp_lvl;
  logic        mreq_valid;
  logic        mreq_ready = 1'b0;
  logic [47:0] mreq_addr;
  logic        mrsp_valid = 1'b0;
  logic [63:0] mrsp_data = '0;

  always #4 clk = ~clk;

  gpa_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .root_we_i(root_we), .root_pfn_i(root_pfn),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_gpa_i(req_gpa),
    .rsp_valid_o(rsp_valid), .rsp_hpa_o(rsp_hpa), .rsp_fault_o(rsp_fault),
    .rsp_lvl_o(rsp_lvl),
    .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready),
    .mem_req_addr_o(mreq_addr),
    .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model
  logic [63:0] mem [logic [47:0]];
  logic [47:0] rd_log [8];
  int          n_rd = 0;
  int          lat = 0;
  int          stall = 0;
  int          stall_left = 0;
  bit          pend = 0;
  int          cnt = 0;
  logic [47:0] pend_a = '0;

  initial forever begin
    @(negedge clk);
    mrsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mrsp_valid = 1'b1;
        mrsp_data  = mem.exists(pend_a) ? mem[pend_a] : 64'h0;
        pend = 0;
      end else cnt--;
    end
    mreq_ready = 1'b0;
    if (mreq_valid && !pend && !mrsp_valid) begin
      if (stall_left > 0) stall_left--;
      else begin
        mreq_ready = 1'b1;
        pend = 1;
        cnt = lat;
        pend_a = mreq_addr;
        if (n_rd < 8) rd_log[n_rd] = mreq_addr;
        n_rd++;
        stall_left = stall;
      end
    end
  end

  function automatic logic [63:0] mk(logic [35:0] pfn, bit p);
    return {16'hDEAD, pfn, 11'h7FE, p};
  endfunction

  function automatic logic [8:0] ix(logic [47:0] g, int lv);
    return g[12 + lv*9 +: 9];
  endfunction

  logic [47:0] exp_a [4];

  // frames: tables at root, f[0], f[1], f[2]; leaf frame f[3]; absent at level code 'miss' (-1 none)
  task automatic build(logic [47:0] g, logic [35:0] root, logic [35:0] f [4], int miss);
    logic [35:0] tb;
    mem.delete();
    tb = root;
    for (int s = 0; s < 4; s++) begin
      exp_a[s] = {tb, ix(g, 3 - s), 3'b000};
      mem[exp_a[s]] = mk(f[s], (3 - s) != miss);
      tb = f[s];
    end
  endtask

  task automatic set_root(logic [35:0] r);
    @(negedge clk);
    root_we = 1'b1; root_pfn = r;
    @(negedge clk);
    root_we = 1'b0;
  endtask

  logic [47:0] got_hpa;
  logic        got_fault;
  logic [1:0]  got_lvl;

  // drives request, optional junk request during walk, optional root write mid-walk
  task automatic walk(logic [47:0] g, bit poke, logic [35:0] new_root, string req);
    int t;
    @(negedge clk);
    n_rd = 0;
    req_valid = 1'b1; req_gpa = g;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_valid = 1'b1; req_gpa = ~g;
      root_we = 1'b1; root_pfn = new_root;
      @(negedge clk);
      root_we = 1'b0;
      chk(req_ready == 1'b0, "R7", "ready during walk", {63'h0, req_ready}, 64'h0);
    end
    t = 0;
    while (!rsp_valid && t < 500) begin
      @(negedge clk);
      t++;
    end
    req_valid = 1'b0;
    chk(t < 500, req, "response arrives", t, 0);
    got_hpa = rsp_hpa; got_fault = rsp_fault; got_lvl = rsp_lvl;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", "single pulse", {63'h0, rsp_valid}, 64'h0);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready, "R8", "no extra response", {63'h0, rsp_valid}, 64'h0);
  endtask

  task automatic check_ok(logic [47:0] g, logic [35:0] leaf, string req);
    chk(got_fault == 1'b0, "R4", "no fault", {63'h0, got_fault}, 64'h0);
    chk(got_hpa == {leaf, g[11:0]}, req, "hpa", got_hpa, {leaf, g[11:0]});
    chk(n_rd == 4, "R2", "read count", n_rd, 4);
    for (int s = 0; s < 4; s++)
      chk(rd_log[s] == exp_a[s], "R3", $sformatf("read %0d address", s), rd_log[s], exp_a[s]);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1", "reset ready", {63'h0, req_ready}, 64'h1);
    chk(rsp_valid == 1'b0, "R1", "reset rsp", {63'h0, rsp_valid}, 64'h0);
    chk(mreq_valid == 1'b0, "R1", "reset mem valid", {63'h0, mreq_valid}, 64'h0);
  endtask

  task automatic t_basic;
    logic [35:0] f [4];
    logic [47:0] g;
    f = '{36'h200, 36'h300, 36'h400, 36'hABCDE};
    g = {9'h1A5, 9'h033, 9'h100, 9'h0FF, 12'h5C7};
    set_root(36'h100);
    build(g, 36'h100, f, -1);
    lat = 0; stall = 0; stall_left = 0;
    walk(g, 0, 36'h0, "R4");
    check_ok(g, f[3], "R4");
  endtask

  task automatic t_edges;
    logic [35:0] f [4];
    logic [47:0] g;
    f = '{36'hFFFFFFFFF, 36'h000000001, 36'h800000000, 36'hFFFFFFFFF};
    g = 48'hFFFF_FFFF_FFFF;
    set_root(36'h7);
    build(g, 36'h7, f, -1);
    walk(g, 0, 36'h0, "R2");
    check_ok(g, f[3], "R2");
  endtask

  task automatic t_faults;
    logic [35:0] f [4];
    logic [47:0] g;
    f = '{36'h11, 36'h22, 36'h33, 36'h44};
    g = {9'h001, 9'h002, 9'h003, 9'h004, 12'hFFF};
    set_root(36'h55);
    for (int lv = 3; lv >= 0; lv--) begin
      build(g, 36'h55, f, lv);
      walk(g, 0, 36'h0, "R5");
      chk(got_fault == 1'b1, "R5", $sformatf("fault lvl %0d", lv), {63'h0, got_fault}, 64'h1);
      chk(got_lvl == lv[1:0], "R5", "fault level code", got_lvl, lv);
      chk(got_hpa == 48'h0, "R5", "fault hpa", got_hpa, 0);
      chk(n_rd == 4 - lv, "R5", "reads before stop", n_rd, 4 - lv);
    end
  endtask

  task automatic t_slow;
    logic [35:0] f [4];
    logic [47:0] g;
    f = '{36'h9001, 36'h9002, 36'h9003, 36'h12345};
    g = {9'h1FF, 9'h000, 9'h155, 9'h0AA, 12'h000};
    set_root(36'h9000);
    build(g, 36'h9000, f, -1);
    lat = 6; stall = 3; stall_left = 3;
    walk(g, 0, 36'h0, "R10");
    check_ok(g, f[3], "R10");
    lat = 0; stall = 0; stall_left = 0;
  endtask

  task automatic t_busy_root;
    logic [35:0] f [4];
    logic [35:0] h [4];
    logic [47:0] g;
    f = '{36'hA1, 36'hA2, 36'hA3, 36'hBEEF0};
    g = {9'h0C3, 9'h1E1, 9'h00F, 9'h111, 12'h9A9};
    set_root(36'hA0);
    build(g, 36'hA0, f, -1);
    lat = 2;
    // junk request and root write presented mid-walk
    walk(g, 1, 36'hC0, "R9");
    check_ok(g, f[3], "R7");
    h = '{36'hC1, 36'hC2, 36'hC3, 36'hCAFE0};
    build(g, 36'hC0, h, -1);
    walk(g, 0, 36'h0, "R9");
    check_ok(g, h[3], "R9");
    lat = 0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_edges();
    t_faults();
    t_slow();
    t_busy_root();
    finish_run();
  end
endmodule